// File: doc/BRIEF.md
# Processor Execution State Controller

This block sequences a processor core between three top-level conditions: running instructions, handling an exception, and a permanent halt. It also owns the supervisor/user privilege bit and the three-bit function code that tags each bus access. The controller picks the highest-priority pending event and starts an exception. It then steps through three phases: stacking the old status, fetching the vector, and refilling the pipeline. The stacking engine, the vector fetch and the instruction pipe sit outside the block and talk to it through request/done handshakes.

A privileged STOP puts the core into a quiet sub-state of normal processing. In that sub-state no bus cycles run and only an interrupt or a trace event can wake it. An access error or address error that arrives while an exception is already being handled means the machine state cannot be saved. The controller then halts, and only reset brings it back. Reset itself is treated as an exception in supervisor mode that begins directly with the vector fetch.

Top module: `exec_state_ctrl`

## Requirements
- R1: `state` always holds one of three encodings: 0 = normal processing, 1 = exception processing, 2 = halted.
- R2: While and after reset, the controller is in exception processing with `s_bit`=1, `exc_cause`=0 (reset), `vec_req`=1 and `stack_req`=0, so the stacking step is skipped.
- R3: An exception runs its steps in a fixed order. First `stack_req` stays high until `stack_done`. Then `vec_req` stays high until `vec_done`. The cycle after `vec_done`, `flush` pulses for one cycle. The controller then waits for `hdl_start` and returns to normal processing the cycle after it.
- R4: In normal processing (not stopped), an event enters exception processing. With several events at once, the lowest cause code wins: address error 1, access error 2, privilege violation or illegal instruction 3, trap 4, trace 5, interrupt 6. The winner appears on `exc_cause`.
- R5: An access error or address error during exception processing moves to halted the next cycle. Halted sets `bus_idle`=1 and ignores every input except reset. All other events are ignored during exception processing.
- R6: A STOP request in supervisor mode sets `stopped`=1 and `bus_idle`=1 while `state` stays 0. While stopped, trap, illegal, error and SR-write inputs have no effect. An interrupt or trace event clears `stopped` and starts exception processing.
- R7: On exception entry, `s_bit` becomes 1 and `stk_old_s` shows the privilege bit from before entry while `stack_req` is high.
- R8: An SR write in supervisor mode loads `sr_wr_s` into `s_bit` on the next cycle, with a one-cycle `flush` pulse in that same cycle.
- R9: An SR write or STOP request issued in user mode leaves the privilege bit unchanged and raises a privilege violation (cause 3, `stk_old_s`=0).
- R10: `fc` is registered: {`s_bit`, `acc_prog`, not `acc_prog`} from the previous cycle. This gives 1 for user data, 2 for user program, 5 for supervisor data and 6 for supervisor program; the reset value is 6.
- R11: While `bus_busy` is 1, `fc` holds its value whatever `acc_prog` and the privilege bit do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_trace | input | 1 | Trace event |
| ev_trap | input | 1 | Trap instruction event |
| ev_illegal | input | 1 | Privileged or illegal instruction detected by decode |
| ev_irq | input | 1 | Interrupt pending |
| ev_acc_err | input | 1 | Access error |
| ev_addr_err | input | 1 | Address error |
| stop_req | input | 1 | STOP instruction executing |
| sr_wr | input | 1 | Status register write completing |
| sr_wr_s | input | 1 | New privilege bit carried by the SR write |
| stack_done | input | 1 | External stacking finished |
| vec_done | input | 1 | External vector fetch finished |
| hdl_start | input | 1 | First handler instruction started |
| acc_prog | input | 1 | Next access is a program (1) or data (0) access |
| bus_busy | input | 1 | A bus cycle is in progress |
| state | output | 2 | Current processing state |
| stopped | output | 1 | STOP sub-state of normal processing |
| s_bit | output | 1 | Supervisor privilege bit |
| bus_idle | output | 1 | No bus cycles will be issued |
| stack_req | output | 1 | Request to save the status register on the supervisor stack |
| stk_old_s | output | 1 | Privilege bit being saved |
| vec_req | output | 1 | Vector fetch request |
| exc_cause | output | 3 | Cause of the current exception |
| flush | output | 1 | Pipeline flush pulse |
| fc | output | 3 | Function code of bus accesses |

## Verification
The bench sends a second error into each exception step and expects a halt that survives interrupts. A design that treated such a nested error as a new exception would loop instead of halting. It also raises several events in the same cycle, where a wrong priority shows up as a different cause code. While the core is stopped, the bench applies traps and SR writes. A controller that confused stopping with halting would never wake, and one that ignored the stop would accept the trap. User-mode SR writes and STOP requests are checked to be caught as privilege violations. The function code is checked to stay frozen while a bus cycle is in progress.

// File: rtl/esc_pkg.sv
package esc_pkg;

    localparam int unsigned N_EV   = 6;
    localparam int unsigned CAU_W  = 3;
    localparam int unsigned FC_W   = 3;

    typedef enum logic [1:0] {
        PH_NORM = 2'd0,
        PH_EXC  = 2'd1,
        PH_HALT = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        XS_SAVE = 2'd0,
        XS_VEC  = 2'd1,
        XS_FILL = 2'd2
    } xstep_e;

    typedef enum logic [CAU_W-1:0] {
        C_RESET = 3'd0,
        C_ADDR  = 3'd1,
        C_ACC   = 3'd2,
        C_PRIV  = 3'd3,
        C_TRAP  = 3'd4,
        C_TRACE = 3'd5,
        C_IRQ   = 3'd6,
        C_NONE  = 3'd7
    } cause_e;

    typedef struct packed {
        phase_e          phase;
        xstep_e          step;
        logic            stopped;
        logic            s;
        cause_e          cause;
        logic            old_s;
        logic            flush;
        logic [FC_W-1:0] fc;
    } ctl_t;

endpackage

// File: rtl/esc_evt_arb.sv
// Fixed-priority pick: bit 0 is the most urgent event.
module esc_evt_arb #(
    parameter int unsigned N     = 6,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     ev_vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ev_vec[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/esc_fc_enc.sv
// Function code: privilege in the top bit, program/data in the low two.
module esc_fc_enc #(
    parameter int unsigned W = 3
) (
    input  logic         sup,
    input  logic         prog,
    output logic [W-1:0] fc
);
    always_comb begin
        fc = '0;
        fc[W-1] = sup;
        fc[1]   = prog;
        fc[0]   = ~prog;
    end
endmodule

// File: rtl/exec_state_ctrl.sv
module exec_state_ctrl
    import esc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_trace,
    input  logic        ev_trap,
    input  logic        ev_illegal,
    input  logic        ev_irq,
    input  logic        ev_acc_err,
    input  logic        ev_addr_err,
    input  logic        stop_req,
    input  logic        sr_wr,
    input  logic        sr_wr_s,
    input  logic        stack_done,
    input  logic        vec_done,
    input  logic        hdl_start,
    input  logic        acc_prog,
    input  logic        bus_busy,
    output logic [1:0]  state,
    output logic        stopped,
    output logic        s_bit,
    output logic        bus_idle,
    output logic        stack_req,
    output logic        stk_old_s,
    output logic        vec_req,
    output logic [2:0]  exc_cause,
    output logic        flush,
    output logic [2:0]  fc
);
    localparam int unsigned IDX_W = $clog2(N_EV);
    // Events allowed to wake the stopped sub-state: trace and interrupt.
    localparam logic [N_EV-1:0] WAKE_MASK = N_EV'(6'b11_0000);
    localparam ctl_t RST_VAL = '{
        phase:   PH_EXC,
        step:    XS_VEC,
        stopped: 1'b0,
        s:       1'b1,
        cause:   C_RESET,
        old_s:   1'b1,
        flush:   1'b0,
        fc:      FC_W'(3'b110)
    };

    ctl_t q, n;

    logic              priv_viol;
    logic [N_EV-1:0]   run_ev;
    logic [N_EV-1:0]   ev_vec;
    logic              ev_hit;
    logic [IDX_W-1:0]  ev_idx;
    cause_e            ev_cause;
    logic [FC_W-1:0]   fc_now;
    logic              nest_err;

    // User-mode attempts at privileged actions become a violation event.
    assign priv_viol = ~q.s & (sr_wr | stop_req);
    assign run_ev    = {ev_irq, ev_trace, ev_trap, ev_illegal | priv_viol,
                        ev_acc_err, ev_addr_err};
    assign ev_vec    = q.stopped ? (run_ev & WAKE_MASK) : run_ev;
    assign nest_err  = ev_acc_err | ev_addr_err;

    esc_evt_arb #(.N(N_EV)) u_arb (
        .ev_vec (ev_vec),
        .hit    (ev_hit),
        .idx    (ev_idx)
    );

    // Cause codes are one above the arbiter index (0 is reserved for reset).
    assign ev_cause = cause_e'(CAU_W'(ev_idx) + CAU_W'(1));

    esc_fc_enc #(.W(FC_W)) u_fc (
        .sup  (q.s),
        .prog (acc_prog),
        .fc   (fc_now)
    );

    always_comb begin
        n       = q;
        n.flush = 1'b0;
        n.fc    = bus_busy ? q.fc : fc_now;
        unique case (q.phase)
            PH_NORM: begin
                if (ev_hit) begin
                    n.phase   = PH_EXC;
                    n.step    = XS_SAVE;
                    n.stopped = 1'b0;
                    n.old_s   = q.s;
                    n.s       = 1'b1;
                    n.cause   = ev_cause;
                end else if (!q.stopped && stop_req) begin
                    n.stopped = 1'b1;
                end else if (!q.stopped && sr_wr) begin
                    n.s     = sr_wr_s;
                    n.flush = 1'b1;
                end
            end
            PH_EXC: begin
                if (nest_err) begin
                    n.phase = PH_HALT;
                end else begin
                    unique case (q.step)
                        XS_SAVE: if (stack_done) n.step = XS_VEC;
                        XS_VEC: begin
                            if (vec_done) begin
                                n.step  = XS_FILL;
                                n.flush = 1'b1;
                            end
                        end
                        XS_FILL: if (hdl_start) n.phase = PH_NORM;
                        default: n.step = XS_SAVE;
                    endcase
                end
            end
            PH_HALT: n.phase = PH_HALT;
            default: n.phase = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= n;
    end

    assign state     = q.phase;
    assign stopped   = q.stopped;
    assign s_bit     = q.s;
    assign bus_idle  = (q.phase == PH_HALT) | q.stopped;
    assign stack_req = (q.phase == PH_EXC) & (q.step == XS_SAVE);
    assign stk_old_s = q.old_s;
    assign vec_req   = (q.phase == PH_EXC) & (q.step == XS_VEC);
    assign exc_cause = q.cause;
    assign flush     = q.flush;
    assign fc        = q.fc;

endmodule

// File: rtl/esc_chk.sv
module esc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_acc_err,
    input logic       ev_addr_err,
    input logic       bus_busy,
    input logic [1:0] state,
    input logic       stopped,
    input logic       s_bit,
    input logic       bus_idle,
    input logic       stack_req,
    input logic       vec_req,
    input logic [2:0] fc
);
    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);

    a_r3_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(stack_req && vec_req));

    a_r5_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && (ev_acc_err || ev_addr_err)) |=> state == 2'd2);

    a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state == 2'd2 |=> (state == 2'd2 && bus_idle));

    a_r6_stop_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (state == 2'd0 && bus_idle));

    a_r7_entry_supervisor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stack_req) |-> (s_bit && state == 2'd1));

    a_r9_user_s_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && !s_bit) |=> (!s_bit || state == 2'd1));

    a_r11_fc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> $stable(fc));
endmodule

bind exec_state_ctrl esc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_acc_err  (ev_acc_err),
    .ev_addr_err (ev_addr_err),
    .bus_busy    (bus_busy),
    .state       (state),
    .stopped     (stopped),
    .s_bit       (s_bit),
    .bus_idle    (bus_idle),
    .stack_req   (stack_req),
    .vec_req     (vec_req),
    .fc          (fc)
);

// File: tb/exec_state_ctrl_tb.sv
`timescale 1ns/1ps
module exec_state_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_trace = 0, ev_trap = 0, ev_illegal = 0, ev_irq = 0;
    logic ev_acc_err = 0, ev_addr_err = 0;
    logic stop_req = 0, sr_wr = 0, sr_wr_s = 0;
    logic stack_done = 0, vec_done = 0, hdl_start = 0;
    logic acc_prog = 1, bus_busy = 0;
    logic [1:0] state;
    logic stopped, s_bit, bus_idle, stack_req, stk_old_s, vec_req, flush;
    logic [2:0] exc_cause, fc;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    exec_state_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_trace(ev_trace), .ev_trap(ev_trap), .ev_illegal(ev_illegal),
        .ev_irq(ev_irq), .ev_acc_err(ev_acc_err), .ev_addr_err(ev_addr_err),
        .stop_req(stop_req), .sr_wr(sr_wr), .sr_wr_s(sr_wr_s),
        .stack_done(stack_done), .vec_done(vec_done), .hdl_start(hdl_start),
        .acc_prog(acc_prog), .bus_busy(bus_busy),
        .state(state), .stopped(stopped), .s_bit(s_bit), .bus_idle(bus_idle),
        .stack_req(stack_req), .stk_old_s(stk_old_s), .vec_req(vec_req),
        .exc_cause(exc_cause), .flush(flush), .fc(fc)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected below 20000", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic finish_exc();
        stack_done = 1; step(); stack_done = 0;
        vec_done = 1;   step(); vec_done = 0;
        hdl_start = 1;  step(); hdl_start = 0;
        chk("R3 back to normal", state, 0);
    endtask

    task automatic to_normal();
        do_reset();
        vec_done = 1;  step(); vec_done = 0;
        hdl_start = 1; step(); hdl_start = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2 state", state, 1);
        chk("R2 s_bit", s_bit, 1);
        chk("R2 cause", exc_cause, 0);
        chk("R2 vec_req", vec_req, 1);
        chk("R2 stack_req", stack_req, 0);
        chk("R10 fc reset", fc, 6);
        vec_done = 1; step(); vec_done = 0;
        chk("R3 vec_req drops", vec_req, 0);
        chk("R3 flush pulse", flush, 1);
        step();
        chk("R3 flush one cycle", flush, 0);
        chk("R3 waits handler", state, 1);
        hdl_start = 1; step(); hdl_start = 0;
        chk("R1 normal", state, 0);
    endtask

    task automatic t_sr_write();
        to_normal();
        sr_wr = 1; sr_wr_s = 0; step(); sr_wr = 0;
        chk("R8 s cleared", s_bit, 0);
        chk("R8 flush", flush, 1);
        acc_prog = 0; step(); step();
        chk("R10 user data fc", fc, 1);
        acc_prog = 1; step();
        chk("R10 user prog fc", fc, 2);
        sr_wr = 1; sr_wr_s = 1; step(); sr_wr = 0; sr_wr_s = 0;
        chk("R9 priv state", state, 1);
        chk("R9 priv cause", exc_cause, 3);
        chk("R7 old s", stk_old_s, 0);
        chk("R7 s set", s_bit, 1);
        chk("R3 stack_req", stack_req, 1);
        stack_done = 1; step(); stack_done = 0;
        chk("R3 vec after stack", vec_req, 1);
        ev_trap = 1; step(); ev_trap = 0;
        chk("R5 trap ignored in exc", exc_cause, 3);
        chk("R5 still exc", state, 1);
        vec_done = 1; step(); vec_done = 0;
        hdl_start = 1; step(); hdl_start = 0;
        chk("R3 normal after handler", state, 0);
    endtask

    task automatic t_priority();
        to_normal();
        ev_trap = 1; ev_trace = 1; ev_irq = 1; step();
        ev_trap = 0; ev_trace = 0; ev_irq = 0;
        chk("R4 trap over trace/irq", exc_cause, 4);
        finish_exc();
        ev_acc_err = 1; ev_addr_err = 1; ev_illegal = 1; step();
        ev_acc_err = 0; ev_addr_err = 0; ev_illegal = 0;
        chk("R4 addr err first", exc_cause, 1);
        chk("R4 entered exc", state, 1);
        finish_exc();
        ev_irq = 1; step(); ev_irq = 0;
        chk("R4 irq cause", exc_cause, 6);
        finish_exc();
    endtask

    task automatic t_stop();
        to_normal();
        stop_req = 1; step(); stop_req = 0;
        chk("R6 stopped", stopped, 1);
        chk("R6 state normal", state, 0);
        chk("R6 bus idle", bus_idle, 1);
        ev_trap = 1; sr_wr = 1; sr_wr_s = 0; ev_acc_err = 1; step();
        ev_trap = 0; sr_wr = 0; ev_acc_err = 0;
        chk("R6 trap ignored", state, 0);
        chk("R6 sr write ignored", s_bit, 1);
        chk("R6 still stopped", stopped, 1);
        ev_trace = 1; step(); ev_trace = 0;
        chk("R6 trace wakes", state, 1);
        chk("R6 trace cause", exc_cause, 5);
        chk("R6 stopped cleared", stopped, 0);
        finish_exc();
        sr_wr = 1; sr_wr_s = 0; step(); sr_wr = 0;
        stop_req = 1; step(); stop_req = 0;
        chk("R9 user stop cause", exc_cause, 3);
        chk("R9 user stop not stopped", stopped, 0);
        finish_exc();
    endtask

    task automatic t_halt();
        to_normal();
        ev_trap = 1; step(); ev_trap = 0;
        ev_acc_err = 1; step(); ev_acc_err = 0;
        chk("R5 halted", state, 2);
        chk("R5 halt bus idle", bus_idle, 1);
        ev_irq = 1; hdl_start = 1; step(); ev_irq = 0; hdl_start = 0;
        chk("R5 halt sticky", state, 2);
        do_reset();
        chk("R5 reset leaves halt", state, 1);
        vec_done = 1; step(); vec_done = 0;
        ev_addr_err = 1; step(); ev_addr_err = 0;
        chk("R5 addr err in fill halts", state, 2);
    endtask

    task automatic t_fc_hold();
        to_normal();
        acc_prog = 0; step(); step();
        chk("R10 sup data fc", fc, 5);
        bus_busy = 1; acc_prog = 1; step();
        sr_wr = 1; sr_wr_s = 0; step(); sr_wr = 0; step();
        chk("R11 fc held", fc, 5);
        bus_busy = 0; step();
        chk("R11 fc updates after bus", fc, 2);
    endtask

    initial begin
        step();
        t_reset();
        t_sr_write();
        t_priority();
        t_stop();
        t_halt();
        t_fc_hold();
        summary();
    end
endmodule